// File: doc/BRIEF.md
# Framed Serial Two's Complementer

This block negates a serial bit stream one 4-bit word at a time. Bits arrive on a single data input, one per clock, least significant bit first. Each run of four consecutive bits is taken as one word. On a single data output, in the same cycle as each input bit, the block presents the matching bit of that word's two's complement. The word boundaries come only from an internal position counter. No framing pin or carry pin exists. All arithmetic history lives in the machine state.

The state is a bit-position counter and one flag. The flag records whether a 1 has already appeared in the current word. While the flag is clear, the output copies the input, and this includes the first 1 itself. Once the flag is set, the output is the inverse of the input. The flag clears when the word ends, so the next word starts fresh. The output is a Mealy function of the current state and the input bit, so it carries no latency.

Top module: `serial_negator`

## Requirements
- R1: While `rst_n` is low, the machine is at word position 0 with the flag clear. Therefore `bit_out` equals `bit_in` during reset.
- R2: Within a word, up to and including the first input bit that is 1, `bit_out` equals `bit_in`.
- R3: Within a word, every input bit after the first 1 appears inverted on `bit_out`.
- R4: `bit_out` depends combinationally on `bit_in` and the state. A change of `bit_in` within a cycle shows on `bit_out` in that cycle, with no clock edge in between.
- R5: A word is exactly four clock cycles long. After the fourth bit, the position returns to 0 and the flag clears, even when that fourth bit was the word's first 1.
- R6: A word of four zero bits produces four zero output bits.
- R7: For every 4-bit word value w, sent bit 0 first, the four output bits form (~w + 1) mod 16, also bit 0 first.
- R8: The input stream 0101 0001 1100 0100 (in time order) produces the output stream 0110 0001 1011 0111.
- R9: Pulling `rst_n` low clears the state at once, without waiting for a clock edge. After release, the next bit is treated as bit 0 of a new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| bit_in | input | 1 | Serial word bits, least significant bit first |
| bit_out | output | 1 | Serial two's-complement bits, same cycle as `bit_in` |

## Verification
Two events can land on the same clock edge: the detection of a word's first 1 and the word-boundary clear. This happens when the only 1 in a word sits in its last position. Such a word would set the flag and end the frame on the same edge. The bench provokes this with the word 8 (bits 0,0,0,1), followed at once by an all-zero word and then by the word 1. It judges the result by requiring the last bit of the word 8 to pass through unchanged. It also requires the next word to give all zeros, which shows that no set flag leaked across the boundary.

// File: rtl/serneg_pkg.sv
package serneg_pkg;
  localparam int unsigned FRAME_LEN_DEFAULT = 4;

  typedef enum logic {
    SCAN_COPY   = 1'b0,
    SCAN_INVERT = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/frame_pos_counter.sv
module frame_pos_counter #(
  parameter int unsigned FRAME_LEN = 4,
  localparam int unsigned POS_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [POS_W-1:0] pos,
  output logic             frame_last
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    if (pos_q == LAST_POS) begin
      pos_d = '0;
    end else begin
      pos_d = pos_q + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (en) begin
      pos_q <= pos_d;
    end
  end

  assign pos        = pos_q;
  assign frame_last = (pos_q == LAST_POS);
endmodule

// File: rtl/seen_one_tracker.sv
module seen_one_tracker
  import serneg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       bit_in,
  input  logic       frame_last,
  output scan_mode_e mode
);
  scan_mode_e mode_q;
  scan_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (frame_last) begin
      mode_d = SCAN_COPY;
    end else if (bit_in) begin
      mode_d = SCAN_INVERT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SCAN_COPY;
    end else if (en) begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/negate_out_mux.sv
module negate_out_mux
  import serneg_pkg::*;
(
  input  logic       bit_in,
  input  scan_mode_e mode,
  output logic       bit_out
);
  always_comb begin
    unique case (mode)
      SCAN_INVERT: bit_out = ~bit_in;
      default:     bit_out = bit_in;
    endcase
  end
endmodule

// File: rtl/serial_negator.sv
module serial_negator
  import serneg_pkg::*;
#(
  parameter int unsigned FRAME_LEN = FRAME_LEN_DEFAULT,
  localparam int unsigned POS_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic bit_out
);
  logic             step_en;
  logic [POS_W-1:0] pos_q;
  logic             frame_last;
  scan_mode_e       mode;
  logic             seen_q;

  assign step_en = 1'b1;
  assign seen_q  = (mode == SCAN_INVERT);

  frame_pos_counter #(.FRAME_LEN(FRAME_LEN)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (step_en),
    .pos        (pos_q),
    .frame_last (frame_last)
  );

  seen_one_tracker u_seen (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (step_en),
    .bit_in     (bit_in),
    .frame_last (frame_last),
    .mode       (mode)
  );

  negate_out_mux u_out (
    .bit_in  (bit_in),
    .mode    (mode),
    .bit_out (bit_out)
  );
endmodule

// File: rtl/serneg_checker.sv
module serneg_checker #(
  parameter int unsigned FRAME_LEN = 4,
  localparam int unsigned POS_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_in,
  input logic [POS_W-1:0] pos,
  input logic             seen
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  // R5: position wraps to 0 after the last bit of a frame
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST_POS) |=> (pos == '0));

  // R5: position advances by one inside a frame
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != LAST_POS) |=> (pos == $past(pos) + POS_W'(1)));

  // R5: flag is clear at the start of every frame
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST_POS) |=> !seen);

  // R2: a 1 before the last position arms inversion for the next bit
  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_in && pos != LAST_POS) |=> seen);

  // R3: once armed, inversion holds until the frame ends
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pos != LAST_POS) |=> seen);

  // R6: zero bits do not arm inversion
  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !bit_in) |=> !seen);
endmodule

bind serial_negator serneg_checker #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .bit_in (bit_in),
  .pos    (pos_q),
  .seen   (seen_q)
);

// File: tb/tb_serial_negator.sv
module tb_serial_negator;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  logic bit_in;
  logic bit_out;
  int   n_total;
  int   n_fail;
  bit   done;

  serial_negator dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (bit_in),
    .bit_out (bit_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [3:0] w, input string req);
    logic [3:0] neg;
    neg = 4'(~w + 4'd1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bit_in = w[i];
      #1;
      check(bit_out, neg[i], req);
    end
  endtask

  task automatic test_reset_state();
    rst_n  = 1'b0;
    bit_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(bit_out, 1'b1, "R1 reset copy of 1");
    bit_in = 1'b0;
    #1;
    check(bit_out, 1'b0, "R1 reset copy of 0");
    @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  task automatic test_same_cycle();
    @(negedge clk);
    bit_in = 1'b0;
    #1;
    check(bit_out, 1'b0, "R4 follow low");
    bit_in = 1'b1;
    #1;
    check(bit_out, 1'b1, "R4 follow high same cycle");
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      bit_in = 1'b0;
      #1;
      check(bit_out, 1'b1, "R3 invert after first one");
    end
  endtask

  task automatic test_copy_invert();
    send_word(4'b0100, "R2 copy through first one");
    send_word(4'b1011, "R3 invert after first one");
  endtask

  task automatic test_boundary();
    send_word(4'b1000, "R5 first one on last bit");
    send_word(4'b0000, "R5 fresh frame after boundary");
    send_word(4'b0001, "R5 second fresh frame");
  endtask

  task automatic test_zero_word();
    send_word(4'b0000, "R6 zero word");
    send_word(4'b0000, "R6 zero word repeat");
  endtask

  task automatic test_all_words();
    for (int v = 0; v < 16; v++) begin
      send_word(4'(v), "R7 exhaustive word");
    end
  endtask

  task automatic test_example();
    logic [15:0] xs;
    logic [15:0] zs;
    xs = 16'b0101_0001_1100_0100;
    zs = 16'b0110_0001_1011_0111;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      bit_in = xs[i];
      #1;
      check(bit_out, zs[i], "R8 example stream");
    end
  endtask

  task automatic test_async_reset();
    @(negedge clk);
    bit_in = 1'b1;
    #1;
    check(bit_out, 1'b1, "R9 pre-reset first bit");
    @(negedge clk);
    bit_in = 1'b1;
    #1;
    check(bit_out, 1'b0, "R9 pre-reset inverted bit");
    rst_n = 1'b0;
    #1;
    check(bit_out, 1'b1, "R9 state cleared without clock");
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    send_word(4'b0110, "R9 fresh word after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    n_total = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    bit_in  = 1'b0;
    test_reset_state();
    test_same_cycle();
    test_copy_invert();
    test_boundary();
    test_zero_word();
    test_all_words();
    test_example();
    test_async_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule